// File: doc/BRIEF.md
# Stack and Branch Unit

This unit carries out the control-flow and stack operations of a 16-bit word machine. Each cycle it may accept one decoded operation along with operand values that are already resolved and the address of the next sequential instruction. The operations are push, pop, call, return, unconditional jump, jump-if-nonzero and jump-if-zero. A single LIFO held in on-chip storage serves two purposes: data pushes and pops, and the return addresses saved by call. As a result, a return pops whatever value sits on top, wherever it came from.

The program counter, the write-back value for a pop and the fault flags are all registered. They update on the same clock edge that accepts the operation. When a pop or return finds the stack empty, the underflow flag is raised. When a push or call finds it full, the overflow flag is raised. Both flags stay set until reset. While either flag is set, every later operation is refused, so the stack and the program counter stay frozen and a debugger can inspect them. The register writes themselves are done outside this unit, driven by the write-back strobe.

Top module: `stack_branch_unit`

## Requirements
- R1: After a synchronous active-high reset, `pc` equals `RESET_PC` (default 0), both fault flags and `wb_valid` are 0, and the stack is empty, so a following pop underflows.
- R2: Operation codes are 0 none, 1 push, 2 pop, 3 call, 4 return, 5 jump, 6 jump-if-nonzero, 7 jump-if-zero. A cycle with `op_valid` low, or with code 0, leaves `pc` and the stack unchanged and gives `wb_valid` = 0.
- R3: Push stores `opnd_a` on top. Pop removes the top value, which appears on `wb_data` with `wb_valid` high for exactly the cycle after the edge that accepted it. Values come back in last-in first-out order. Push and pop both load `pc` with `fall_pc`.
- R4: A pop or return on an empty stack sets `fault_under` and changes neither `pc` nor the stack.
- R5: A push or call while the stack holds `DEPTH` entries sets `fault_over` and changes neither `pc` nor the stack.
- R6: Jump loads `pc` with `opnd_a`.
- R7: Jump-if-nonzero loads `pc` with `opnd_b` when any bit of `opnd_a` is set, and with `fall_pc` otherwise.
- R8: Jump-if-zero loads `pc` with `opnd_b` when `opnd_a` is all zeros, and with `fall_pc` otherwise.
- R9: Call pushes `fall_pc` and loads `pc` with `opnd_a`.
- R10: Return pops the top entry into `pc`. It shares the stack with push, so a value pushed as data is returned to as an address.
- R11: A fault flag, once set, stays set until reset. While either flag is set, no operation changes `pc` or the stack and `wb_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation code (see R2) |
| opnd_a | input | W | First resolved operand |
| opnd_b | input | W | Second resolved operand (branch target) |
| fall_pc | input | W | Address of the following instruction |
| pc | output | W | Program counter after the last accepted operation |
| wb_valid | output | 1 | Pop result is on `wb_data` this cycle |
| wb_data | output | W | Value removed by the last pop |
| fault_under | output | 1 | Sticky: pop or return on an empty stack |
| fault_over | output | 1 | Sticky: push or call on a full stack |

## Verification
The bench targets the edges of the stack. It pops and returns on an empty stack and pushes and calls on a full one. A design with a wrapping pointer would hand back stale data or write over the oldest entry instead of raising a flag. Conditional jumps are driven with operands whose only set bit is the top bit, which catches a zero test performed on a single bit or on a signed compare. Calls followed by returns, and data pushes followed by returns, show that both kinds of entry share one stack and that the saved address is the fall-through address rather than the call target. After each fault the bench presents valid pops and jumps and confirms that nothing moves, which exposes a flag that is either not sticky or does not gate updates.

// File: rtl/sbu_pkg.sv
package sbu_pkg;

    typedef enum logic [2:0] {
        SBU_NONE = 3'd0,
        SBU_PUSH = 3'd1,
        SBU_POP  = 3'd2,
        SBU_CALL = 3'd3,
        SBU_RET  = 3'd4,
        SBU_JMP  = 3'd5,
        SBU_JT   = 3'd6,
        SBU_JF   = 3'd7
    } sbu_op_e;

    // Per-operation control: which stack side it uses and whether pop data goes to a register.
    typedef struct packed {
        logic active;
        logic push;
        logic pop;
        logic writes_back;
    } sbu_ctl_t;

    function automatic sbu_ctl_t sbu_decode(sbu_op_e op);
        sbu_ctl_t c;
        c = '0;
        c.active = (op != SBU_NONE);
        c.push = (op == SBU_PUSH) || (op == SBU_CALL);
        c.pop = (op == SBU_POP) || (op == SBU_RET);
        c.writes_back = (op == SBU_POP);
        return c;
    endfunction

endpackage

// File: rtl/sbu_stack.sv
module sbu_stack
    import sbu_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_en,
    input  logic [W-1:0] push_data,
    input  logic         pop_en,
    output logic [W-1:0] top_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
    localparam int PW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] cnt;
    logic [AW-1:0] wr_idx;
    logic [AW-1:0] top_idx;

    assign wr_idx  = cnt[AW-1:0];
    assign top_idx = cnt[AW-1:0] - AW'(1);
    assign empty   = (cnt == '0);
    assign full    = (cnt == PW'(DEPTH));
    assign top_data = mem[top_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (push_en) begin
            cnt <= cnt + PW'(1);
        end else if (pop_en) begin
            cnt <= cnt - PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push_en) begin
            mem[wr_idx] <= push_data;
        end
    end

    // The controller must never push into a full stack (R5) nor pop an empty one (R4).
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        push_en |-> !full);
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        pop_en |-> !empty);
    assert_one_side_R3: assert property (@(posedge clk) disable iff (rst)
        !(push_en && pop_en));

endmodule

// File: rtl/sbu_target.sv
module sbu_target
    import sbu_pkg::*;
#(
    parameter int W = 16
) (
    input  sbu_op_e      op,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [W-1:0] fall_pc,
    input  logic [W-1:0] stack_top,
    output logic [W-1:0] target
);
    logic a_zero;
    assign a_zero = (opnd_a == '0);

    always_comb begin
        unique case (op)
            SBU_CALL,
            SBU_JMP:  target = opnd_a;
            SBU_RET:  target = stack_top;
            SBU_JT:   target = a_zero ? fall_pc : opnd_b;
            SBU_JF:   target = a_zero ? opnd_b : fall_pc;
            default:  target = fall_pc;
        endcase
    end

endmodule

// File: rtl/stack_branch_unit.sv
module stack_branch_unit
    import sbu_pkg::*;
#(
    parameter int          W        = 16,
    parameter int          DEPTH    = 16,
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         op_valid,
    input  logic [2:0]   op_code,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [W-1:0] fall_pc,
    output logic [W-1:0] pc,
    output logic         wb_valid,
    output logic [W-1:0] wb_data,
    output logic         fault_under,
    output logic         fault_over
);
    sbu_op_e  op;
    sbu_ctl_t ctl;
    logic     fault_any, live, hit_over, hit_under, take;
    logic     push_en, pop_en, st_empty, st_full;
    logic [W-1:0] push_data, top_data, target;

    assign op        = sbu_op_e'(op_code);
    assign ctl       = sbu_decode(op);
    assign fault_any = fault_under | fault_over;
    assign live      = op_valid & ctl.active & ~fault_any;
    assign hit_over  = live & ctl.push & st_full;
    assign hit_under = live & ctl.pop & st_empty;
    assign take      = live & ~hit_over & ~hit_under;
    assign push_en   = take & ctl.push;
    assign pop_en    = take & ctl.pop;
    assign push_data = (op == SBU_CALL) ? fall_pc : opnd_a;

    sbu_stack #(.W(W), .DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push_en  (push_en),
        .push_data(push_data),
        .pop_en   (pop_en),
        .top_data (top_data),
        .empty    (st_empty),
        .full     (st_full)
    );

    sbu_target #(.W(W)) u_target (
        .op       (op),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .fall_pc  (fall_pc),
        .stack_top(top_data),
        .target   (target)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc          <= W'(RESET_PC);
            wb_valid    <= 1'b0;
            wb_data     <= '0;
            fault_under <= 1'b0;
            fault_over  <= 1'b0;
        end else begin
            wb_valid <= take & ctl.writes_back;
            if (take & ctl.writes_back) begin
                wb_data <= top_data;
            end
            if (take) begin
                pc <= target;
            end
            if (hit_under) begin
                fault_under <= 1'b1;
            end
            if (hit_over) begin
                fault_over <= 1'b1;
            end
        end
    end

    // Faults are sticky and freeze the program counter (R11).
    assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        fault_any |=> (fault_under | fault_over));
    assert_pc_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        fault_any |=> $stable(pc));
    // An unconditional jump lands on its operand (R6).
    assert_jump_target_R6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd5 && !fault_under && !fault_over) |=> (pc == $past(opnd_a)));
    // Write-back strobes only follow a presented pop (R3).
    assert_wb_after_pop_R3: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(op_valid && op_code == 3'd2));
    // Idle cycles never move the program counter (R2).
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!op_valid || op_code == 3'd0) |=> $stable(pc));

endmodule

// File: tb/stack_branch_unit_tb.sv
module stack_branch_unit_tb;
    localparam int W = 16;
    localparam int DEPTH = 16;
    localparam time HALF = 10ns;

    logic clk = 1'b0;
    logic rst;
    logic op_valid;
    logic [2:0] op_code;
    logic [W-1:0] opnd_a, opnd_b, fall_pc;
    logic [W-1:0] pc, wb_data;
    logic wb_valid, fault_under, fault_over;

    always #HALF clk = ~clk;

    stack_branch_unit #(.W(W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .fall_pc(fall_pc),
        .pc(pc), .wb_valid(wb_valid), .wb_data(wb_data),
        .fault_under(fault_under), .fault_over(fault_over)
    );

    int checks = 0;
    int errors = 0;

    // Bench-side model of the stack and flags.
    logic [W-1:0] mstk [DEPTH];
    int           msp;
    logic [W-1:0] mpc, mwb;
    bit           mfu, mfo, mwbv;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(int op);
        case (op)
            1: return "R3";
            2: return "R3";
            3: return "R9";
            4: return "R10";
            5: return "R6";
            6: return "R7";
            7: return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic model_reset();
        msp = 0; mpc = '0; mfu = 0; mfo = 0; mwbv = 0; mwb = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; op_valid = 1'b0; op_code = '0;
        opnd_a = '0; opnd_b = '0; fall_pc = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // Present one operation at a falling edge, predict, and check at the next falling edge.
    task automatic do_op(int op, logic [W-1:0] a, logic [W-1:0] b,
                         logic [W-1:0] nxt, bit vld, string req);
        mwbv = 0;
        if (vld && op != 0 && !(mfu || mfo)) begin
            case (op)
                1, 3: begin
                    if (msp == DEPTH) mfo = 1;
                    else begin
                        mstk[msp] = (op == 3) ? nxt : a;
                        msp++;
                        mpc = (op == 3) ? a : nxt;
                    end
                end
                2, 4: begin
                    if (msp == 0) mfu = 1;
                    else begin
                        msp--;
                        if (op == 2) begin mwbv = 1; mwb = mstk[msp]; mpc = nxt; end
                        else mpc = mstk[msp];
                    end
                end
                5: mpc = a;
                6: mpc = (a != 0) ? b : nxt;
                7: mpc = (a == 0) ? b : nxt;
                default: ;
            endcase
        end
        op_valid = vld; op_code = 3'(op);
        opnd_a = a; opnd_b = b; fall_pc = nxt;
        @(negedge clk);
        op_valid = 1'b0;
        chk({req, " pc"}, 32'(pc), 32'(mpc));
        chk({req, " wb_valid"}, 32'(wb_valid), 32'(mwbv));
        if (mwbv) chk({req, " wb_data"}, 32'(wb_data), 32'(mwb));
        chk({req, " fault_under"}, 32'(fault_under), 32'(mfu));
        chk({req, " fault_over"}, 32'(fault_over), 32'(mfo));
    endtask

    initial begin
        #(2 * HALF * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        rst = 1'b1;
        do_reset();
        // R1: reset state
        chk("R1 pc", 32'(pc), 32'h0);
        chk("R1 faults", {30'd0, fault_under, fault_over}, 32'h0);
        chk("R1 wb_valid", 32'(wb_valid), 32'h0);

        // R3: LIFO order
        do_op(1, 16'h1234, 16'h0, 16'h0003, 1, "R3");
        do_op(1, 16'hBEEF, 16'h0, 16'h0005, 1, "R3");
        do_op(2, 16'h0, 16'h0, 16'h0007, 1, "R3");
        do_op(2, 16'h0, 16'h0, 16'h0009, 1, "R3");
        // R2: not valid, and the none code, do nothing
        do_op(5, 16'h7777, 16'h0, 16'h0, 0, "R2");
        do_op(0, 16'h7777, 16'h0, 16'h0, 1, "R2");
        // R6, R7, R8 including a top-bit-only operand
        do_op(5, 16'h0100, 16'h0, 16'h0011, 1, "R6");
        do_op(6, 16'h0000, 16'h0200, 16'h0102, 1, "R7");
        do_op(6, 16'h8000, 16'h0300, 16'h0104, 1, "R7");
        do_op(7, 16'h8000, 16'h0400, 16'h0302, 1, "R8");
        do_op(7, 16'h0000, 16'h0500, 16'h0304, 1, "R8");
        // R9, R10: call saves fall-through; data push is returned to
        do_op(3, 16'h0600, 16'h0, 16'h0502, 1, "R9");
        do_op(4, 16'h0, 16'h0, 16'h0601, 1, "R10");
        do_op(1, 16'h0ABC, 16'h0, 16'h0503, 1, "R10");
        do_op(4, 16'h0, 16'h0, 16'h0504, 1, "R10");
        // R4: return on empty stack, then R11 frozen
        do_op(4, 16'h0, 16'h0, 16'h0ABD, 1, "R4");
        do_op(5, 16'h0F00, 16'h0, 16'h0, 1, "R11");
        do_op(1, 16'h0055, 16'h0, 16'h0, 1, "R11");
        do_op(2, 16'h0, 16'h0, 16'h0, 1, "R11");

        // R1: reset clears the flags and empties the stack
        do_reset();
        chk("R1 cleared", {30'd0, fault_under, fault_over}, 32'h0);
        do_op(2, 16'h0, 16'h0, 16'h0001, 1, "R1");

        // R5: fill then overflow by call; R11 blocks pop of a full stack
        do_reset();
        for (int i = 0; i < DEPTH; i++) do_op(1, 16'(i * 3 + 1), 16'h0, 16'(i + 1), 1, "R5");
        do_op(3, 16'h0700, 16'h0, 16'h0020, 1, "R5");
        do_op(2, 16'h0, 16'h0, 16'h0021, 1, "R11");
        do_op(6, 16'h0001, 16'h0800, 16'h0022, 1, "R11");
        do_reset();
        for (int i = 0; i < DEPTH; i++) do_op(3, 16'(i + 40), 16'h0, 16'(i + 200), 1, "R9");
        do_op(1, 16'h0099, 16'h0, 16'h0030, 1, "R5");

        // Random legal traffic against the model
        do_reset();
        for (int i = 0; i < 600; i++) begin
            int op;
            logic [W-1:0] a;
            bit vld;
            op = int'($urandom_range(0, 7));
            if ((op == 2 || op == 4) && msp == 0) op = 1;
            if ((op == 1 || op == 3) && msp == DEPTH) op = 2;
            a = ($urandom_range(0, 3) == 0) ? '0 : W'($urandom);
            vld = ($urandom_range(0, 9) != 0);
            do_op(op, a, W'($urandom), W'($urandom), vld, vld ? tag_of(op) : "R2");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule